// File: doc/BRIEF.md
# Two-Phase Board Strap Capture

This block samples the board's configuration strap pins at two points of a power-up and holds what it sampled as steady configuration outputs for the rest of the chip. The first group is sampled as the resume (standby) reset is released, which is the move from no power to standby. The second group is sampled once for each qualified rise of power-good, the move from standby to running. The raw power-good input is first synchronised and then filtered, so a bounce or a short glitch never starts a capture.

The first group carries a 2-bit boot-ROM type code. The block decodes it into a one-hot selection. The second group carries general straps, a debug group, a watchdog enable and a PCI-ROM-boot enable. A debug-enable strap chooses whether the debug group takes the pin values or a built-in default word. The PCI-ROM-boot option is honoured only on the first running entry after a cold start. Each capture produces a one-cycle valid pulse, so that downstream logic knows when the configuration it reads is settled.

Top module: `strap_capture`

## Requirements
- R1: While the resume reset input `rsm_rst_n` is low, every output is 0, including `rom_sel`, both valid pulses and all captured fields.
- R2: On the first clock edge after `rsm_rst_n` rises, `g1_cfg` and `rom_sel` load from the pins and `g1_valid` is high for that one cycle only. Later changes on the group-I pins have no effect until the next resume reset.
- R3: `pg_raw` passes `SYNC_STAGES` synchroniser flops and must then stay high for `DEB_CYCLES` consecutive clocks before a group-II capture occurs. The capture and `g2_valid` appear `DEB_CYCLES + SYNC_STAGES + 1` clocks after the input rises. A high pulse shorter than `DEB_CYCLES` clocks causes no capture.
- R4: Each filtered power-good rise causes exactly one group-II capture. `g2_valid` is high for one cycle and does not repeat while power-good stays high.
- R5: If `dbg_en_pin` is 0 at capture, `dbg_cfg` takes `DBG_DEFAULT` (all ones by default). If it is 1, `dbg_cfg` takes `dbg_pins`. `dbg_en_cfg` holds the captured enable.
- R6: `rom_sel` is one-hot, indexed by the ROM code on `rom_pins`: code 2'b00 sets bit 0 (firmware hub), 2'b01 sets bit 1 (LPC ROM), 2'b10 sets bit 2 (SPI ROM) and 2'b11 sets bit 3 (reserved).
- R7: `pci_boot_cfg` takes `pci_boot_pin` only at the first group-II capture after a resume reset. Every later capture loads 0 into it.
- R8: `wdt_cfg` takes `wdt_pin` at each group-II capture. It enables the watchdog function on the northbridge power-good output.
- R9: Group-II outputs (`g2_cfg`, `dbg_cfg`, `dbg_en_cfg`, `pci_boot_cfg`, `wdt_cfg`) keep their values when power-good falls and when the pins change. They change only at the next capture or at a resume reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby-domain clock |
| rsm_rst_n | input | 1 | Resume reset, active low, asynchronous assert |
| pg_raw | input | 1 | Unfiltered power-good |
| g1_pins | input | G1_W | Group-I strap pins |
| rom_pins | input | 2 | Boot-ROM type strap (group I) |
| g2_pins | input | G2_W | Group-II general strap pins |
| dbg_en_pin | input | 1 | Debug-enable strap |
| dbg_pins | input | DBG_W | Debug strap pins |
| pci_boot_pin | input | 1 | PCI-ROM-boot enable strap |
| wdt_pin | input | 1 | Watchdog-enable strap |
| g1_cfg | output | G1_W | Captured group-I straps |
| rom_sel | output | 4 | One-hot decoded ROM type |
| g1_valid | output | 1 | One-cycle pulse at group-I capture |
| g2_cfg | output | G2_W | Captured group-II straps |
| dbg_cfg | output | DBG_W | Debug straps, pins or defaults |
| dbg_en_cfg | output | 1 | Captured debug enable |
| pci_boot_cfg | output | 1 | PCI-ROM-boot enable, first capture only |
| wdt_cfg | output | 1 | Captured watchdog enable |
| g2_valid | output | 1 | One-cycle pulse at group-II capture |

## Verification
The properties assume that `rsm_rst_n` is asserted from time zero and that power-good only matters while the resume reset is released. They also assume that any two filtered power-good rises are at least two clocks apart, which the filter guarantees because each rise needs `DEB_CYCLES` high clocks. The stimulus drives every input on the falling clock edge. It changes strap pins only when no capture can be pending, so each captured value is determined. Power-good is kept either well above the filter length or deliberately short for the glitch case, never in between.

// File: rtl/strap_pkg.sv
package strap_pkg;

   localparam int unsigned ROM_KINDS = 4;

   typedef enum logic [1:0] {
      ROM_FWH  = 2'b00,
      ROM_LPC  = 2'b01,
      ROM_SPI  = 2'b10,
      ROM_RSVD = 2'b11
   } rom_kind_e;

   function automatic logic [ROM_KINDS-1:0] rom_onehot(input rom_kind_e kind);
      logic [ROM_KINDS-1:0] sel;
      sel = '0;
      sel[int'(kind)] = 1'b1;
      return sel;
   endfunction

endpackage

// File: rtl/strap_pg_filter.sv
module strap_pg_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DEB_CYCLES  = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pg_raw,
   output logic pg_rise
);
   localparam int unsigned CNT_W = $clog2(DEB_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DEB_CYCLES - 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   pg_sync;
   logic                   deb_q;
   logic                   deb_dly_q;

   // synchroniser chain, one flop per stage
   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= pg_raw;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[s] <= 1'b0;
               else        sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   assign pg_sync = sync_q[SYNC_STAGES-1];

   // filter variant chosen by the qualification length
   generate
      if (DEB_CYCLES == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) deb_q <= 1'b0;
            else        deb_q <= pg_sync;
         end
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               deb_q <= 1'b0;
            end else if (!pg_sync) begin
               cnt_q <= '0;
               deb_q <= 1'b0;
            end else if (cnt_q == CNT_TOP) begin
               deb_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) deb_dly_q <= 1'b0;
      else        deb_dly_q <= deb_q;
   end

   assign pg_rise = deb_q & ~deb_dly_q;

endmodule

// File: rtl/strap_grp1_latch.sv
module strap_grp1_latch
   import strap_pkg::*;
#(
   parameter int unsigned G1_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [G1_W-1:0]      g1_pins,
   input  logic [1:0]           rom_pins,
   output logic [G1_W-1:0]      g1_cfg,
   output logic [ROM_KINDS-1:0] rom_sel,
   output logic                 g1_valid
);
   logic done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q   <= 1'b0;
         g1_cfg   <= '0;
         rom_sel  <= '0;
         g1_valid <= 1'b0;
      end else if (!done_q) begin
         done_q   <= 1'b1;
         g1_cfg   <= g1_pins;
         rom_sel  <= rom_onehot(rom_kind_e'(rom_pins));
         g1_valid <= 1'b1;
      end else begin
         g1_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/strap_grp2_latch.sv
module strap_grp2_latch #(
   parameter int unsigned           G2_W        = 8,
   parameter int unsigned           DBG_W       = 5,
   parameter logic [DBG_W-1:0]      DBG_DEFAULT = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [G2_W-1:0]   g2_pins,
   input  logic              dbg_en_pin,
   input  logic [DBG_W-1:0]  dbg_pins,
   input  logic              pci_boot_pin,
   input  logic              wdt_pin,
   output logic [G2_W-1:0]   g2_cfg,
   output logic [DBG_W-1:0]  dbg_cfg,
   output logic              dbg_en_cfg,
   output logic              pci_boot_cfg,
   output logic              wdt_cfg,
   output logic              g2_valid
);
   logic [DBG_W-1:0] dbg_next;
   logic             cold_q;

   // per-bit choice between pin and built-in default
   generate
      for (genvar b = 0; b < DBG_W; b++) begin : g_dbg
         assign dbg_next[b] = dbg_en_pin ? dbg_pins[b] : DBG_DEFAULT[b];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cold_q       <= 1'b1;
         g2_cfg       <= '0;
         dbg_cfg      <= '0;
         dbg_en_cfg   <= 1'b0;
         pci_boot_cfg <= 1'b0;
         wdt_cfg      <= 1'b0;
         g2_valid     <= 1'b0;
      end else begin
         g2_valid <= capture;
         if (capture) begin
            cold_q       <= 1'b0;
            g2_cfg       <= g2_pins;
            dbg_cfg      <= dbg_next;
            dbg_en_cfg   <= dbg_en_pin;
            pci_boot_cfg <= pci_boot_pin & cold_q;
            wdt_cfg      <= wdt_pin;
         end
      end
   end

endmodule

// File: rtl/strap_capture.sv
module strap_capture
   import strap_pkg::*;
#(
   parameter int unsigned      G1_W        = 8,
   parameter int unsigned      G2_W        = 8,
   parameter int unsigned      DBG_W       = 5,
   parameter logic [DBG_W-1:0] DBG_DEFAULT = '1,
   parameter int unsigned      SYNC_STAGES = 2,
   parameter int unsigned      DEB_CYCLES  = 16
) (
   input  logic                 clk,
   input  logic                 rsm_rst_n,
   input  logic                 pg_raw,
   input  logic [G1_W-1:0]      g1_pins,
   input  logic [1:0]           rom_pins,
   input  logic [G2_W-1:0]      g2_pins,
   input  logic                 dbg_en_pin,
   input  logic [DBG_W-1:0]     dbg_pins,
   input  logic                 pci_boot_pin,
   input  logic                 wdt_pin,
   output logic [G1_W-1:0]      g1_cfg,
   output logic [ROM_KINDS-1:0] rom_sel,
   output logic                 g1_valid,
   output logic [G2_W-1:0]      g2_cfg,
   output logic [DBG_W-1:0]     dbg_cfg,
   output logic                 dbg_en_cfg,
   output logic                 pci_boot_cfg,
   output logic                 wdt_cfg,
   output logic                 g2_valid
);
   // elaboration-time parameter checks
   generate
      if (G1_W < 1 || G2_W < 1 || DBG_W < 1) begin : g_bad_width
         $error("strap_capture: strap widths must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("strap_capture: SYNC_STAGES must be at least 2");
      end
      if (DEB_CYCLES < 1) begin : g_bad_deb
         $error("strap_capture: DEB_CYCLES must be at least 1");
      end
   endgenerate

   logic pg_rise;

   strap_pg_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .DEB_CYCLES  (DEB_CYCLES)
   ) u_pg (
      .clk     (clk),
      .rst_n   (rsm_rst_n),
      .pg_raw  (pg_raw),
      .pg_rise (pg_rise)
   );

   strap_grp1_latch #(
      .G1_W (G1_W)
   ) u_g1 (
      .clk      (clk),
      .rst_n    (rsm_rst_n),
      .g1_pins  (g1_pins),
      .rom_pins (rom_pins),
      .g1_cfg   (g1_cfg),
      .rom_sel  (rom_sel),
      .g1_valid (g1_valid)
   );

   strap_grp2_latch #(
      .G2_W        (G2_W),
      .DBG_W       (DBG_W),
      .DBG_DEFAULT (DBG_DEFAULT)
   ) u_g2 (
      .clk          (clk),
      .rst_n        (rsm_rst_n),
      .capture      (pg_rise),
      .g2_pins      (g2_pins),
      .dbg_en_pin   (dbg_en_pin),
      .dbg_pins     (dbg_pins),
      .pci_boot_pin (pci_boot_pin),
      .wdt_pin      (wdt_pin),
      .g2_cfg       (g2_cfg),
      .dbg_cfg      (dbg_cfg),
      .dbg_en_cfg   (dbg_en_cfg),
      .pci_boot_cfg (pci_boot_cfg),
      .wdt_cfg      (wdt_cfg),
      .g2_valid     (g2_valid)
   );

endmodule

// File: rtl/strap_capture_chk.sv
module strap_capture_chk #(
   parameter int unsigned      G1_W        = 8,
   parameter int unsigned      G2_W        = 8,
   parameter int unsigned      DBG_W       = 5,
   parameter logic [DBG_W-1:0] DBG_DEFAULT = '1
) (
   input logic              clk,
   input logic              rsm_rst_n,
   input logic [G1_W-1:0]   g1_cfg,
   input logic [3:0]        rom_sel,
   input logic              g1_valid,
   input logic [G2_W-1:0]   g2_cfg,
   input logic [DBG_W-1:0]  dbg_cfg,
   input logic              dbg_en_cfg,
   input logic              pci_boot_cfg,
   input logic              wdt_cfg,
   input logic              g2_valid
);
   logic seen1_q;
   logic seen2_q;

   always_ff @(posedge clk or negedge rsm_rst_n) begin
      if (!rsm_rst_n) begin
         seen1_q <= 1'b0;
         seen2_q <= 1'b0;
      end else begin
         if (g1_valid) seen1_q <= 1'b1;
         if (g2_valid) seen2_q <= 1'b1;
      end
   end

   AST_G1_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rsm_rst_n)
      seen1_q |-> !g1_valid); // R2

   AST_G1_HOLD: assert property (@(posedge clk) disable iff (!rsm_rst_n)
      !g1_valid |-> $stable({g1_cfg, rom_sel})); // R2

   AST_ROM_ONE_HOT: assert property (@(posedge clk) disable iff (!rsm_rst_n)
      g1_valid |-> $countones(rom_sel) == 1); // R6

   AST_G2_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rsm_rst_n)
      g2_valid |=> !g2_valid); // R4

   AST_G2_HOLD: assert property (@(posedge clk) disable iff (!rsm_rst_n)
      !g2_valid |-> $stable({g2_cfg, dbg_cfg, dbg_en_cfg, pci_boot_cfg, wdt_cfg})); // R9

   AST_DBG_DEFAULT: assert property (@(posedge clk) disable iff (!rsm_rst_n)
      (g2_valid && !dbg_en_cfg) |-> dbg_cfg == DBG_DEFAULT); // R5

   AST_PCI_BOOT_ONCE: assert property (@(posedge clk) disable iff (!rsm_rst_n)
      (seen2_q && g2_valid) |-> !pci_boot_cfg); // R7

endmodule

bind strap_capture strap_capture_chk #(
   .G1_W        (G1_W),
   .G2_W        (G2_W),
   .DBG_W       (DBG_W),
   .DBG_DEFAULT (DBG_DEFAULT)
) u_chk (
   .clk          (clk),
   .rsm_rst_n    (rsm_rst_n),
   .g1_cfg       (g1_cfg),
   .rom_sel      (rom_sel),
   .g1_valid     (g1_valid),
   .g2_cfg       (g2_cfg),
   .dbg_cfg      (dbg_cfg),
   .dbg_en_cfg   (dbg_en_cfg),
   .pci_boot_cfg (pci_boot_cfg),
   .wdt_cfg      (wdt_cfg),
   .g2_valid     (g2_valid)
);

// File: tb/tb_strap_capture.sv
`timescale 1ns/1ps
module tb_strap_capture;
   localparam int unsigned G1_W  = 8;
   localparam int unsigned G2_W  = 8;
   localparam int unsigned DBG_W = 5;
   localparam logic [DBG_W-1:0] DBG_DEF = '1;
   localparam int unsigned SYNC  = 2;
   localparam int unsigned DEB   = 16;

   logic              clk = 1'b0;
   logic              rsm_rst_n;
   logic              pg_raw;
   logic [G1_W-1:0]   g1_pins;
   logic [1:0]        rom_pins;
   logic [G2_W-1:0]   g2_pins;
   logic              dbg_en_pin;
   logic [DBG_W-1:0]  dbg_pins;
   logic              pci_boot_pin;
   logic              wdt_pin;
   logic [G1_W-1:0]   g1_cfg;
   logic [3:0]        rom_sel;
   logic              g1_valid;
   logic [G2_W-1:0]   g2_cfg;
   logic [DBG_W-1:0]  dbg_cfg;
   logic              dbg_en_cfg;
   logic              pci_boot_cfg;
   logic              wdt_cfg;
   logic              g2_valid;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   strap_capture #(
      .G1_W (G1_W), .G2_W (G2_W), .DBG_W (DBG_W), .DBG_DEFAULT (DBG_DEF),
      .SYNC_STAGES (SYNC), .DEB_CYCLES (DEB)
   ) dut (
      .clk (clk), .rsm_rst_n (rsm_rst_n), .pg_raw (pg_raw),
      .g1_pins (g1_pins), .rom_pins (rom_pins), .g2_pins (g2_pins),
      .dbg_en_pin (dbg_en_pin), .dbg_pins (dbg_pins),
      .pci_boot_pin (pci_boot_pin), .wdt_pin (wdt_pin),
      .g1_cfg (g1_cfg), .rom_sel (rom_sel), .g1_valid (g1_valid),
      .g2_cfg (g2_cfg), .dbg_cfg (dbg_cfg), .dbg_en_cfg (dbg_en_cfg),
      .pci_boot_cfg (pci_boot_cfg), .wdt_cfg (wdt_cfg), .g2_valid (g2_valid)
   );

   function automatic logic [DBG_W-1:0] exp_dbg(input logic en, input logic [DBG_W-1:0] pins);
      return en ? pins : DBG_DEF;
   endfunction

   function automatic logic [3:0] exp_rom(input logic [1:0] code);
      return 4'b0001 << code;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // expected group-II state
   logic [G2_W-1:0]  e_g2;
   logic [DBG_W-1:0] e_dbg;
   logic             e_den, e_pci, e_wdt;

   task automatic check_g2(input string req);
      chk(req, 32'(g2_cfg), 32'(e_g2));
      chk(req, 32'(dbg_cfg), 32'(e_dbg));
      chk(req, 32'(dbg_en_cfg), 32'(e_den));
      chk(req, 32'(pci_boot_cfg), 32'(e_pci));
      chk(req, 32'(wdt_cfg), 32'(e_wdt));
   endtask

   task automatic randomize_pins();
      g1_pins      = G1_W'($urandom);
      rom_pins     = 2'($urandom);
      g2_pins      = G2_W'($urandom);
      dbg_en_pin   = 1'($urandom);
      dbg_pins     = DBG_W'($urandom);
      pci_boot_pin = 1'($urandom);
      wdt_pin      = 1'($urandom);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h51A7_C0DE));
      rsm_rst_n = 1'b0;
      pg_raw    = 1'b0;
      randomize_pins();
      repeat (4) @(negedge clk);
      // R1: reset state
      chk("R1", 32'({g1_cfg, rom_sel, g1_valid}), 32'h0);
      chk("R1", 32'({g2_cfg, dbg_cfg, dbg_en_cfg, pci_boot_cfg, wdt_cfg, g2_valid}), 32'h0);

      for (int cold = 0; cold < 4; cold++) begin
         logic [G1_W-1:0] e_g1;
         logic [1:0]      e_code;
         rsm_rst_n = 1'b0;
         pg_raw    = 1'b0;
         repeat (3) @(negedge clk);
         chk("R1", 32'({g1_cfg, rom_sel, g1_valid}), 32'h0);
         chk("R1", 32'({g2_cfg, dbg_cfg, dbg_en_cfg, pci_boot_cfg, wdt_cfg, g2_valid}), 32'h0);
         e_g2 = '0; e_dbg = '0; e_den = 0; e_pci = 0; e_wdt = 0;

         g1_pins  = G1_W'($urandom);
         rom_pins = 2'(cold);        // every ROM code once
         e_g1     = g1_pins;
         e_code   = rom_pins;
         rsm_rst_n = 1'b1;
         @(negedge clk);
         chk("R2", 32'(g1_valid), 32'd1);
         chk("R2", 32'(g1_cfg), 32'(e_g1));
         chk("R6", 32'(rom_sel), 32'(exp_rom(e_code)));
         g1_pins  = ~e_g1;
         rom_pins = ~e_code;
         @(negedge clk);
         chk("R2", 32'(g1_valid), 32'd0);
         repeat (5) @(negedge clk);
         chk("R2", 32'(g1_cfg), 32'(e_g1));
         chk("R6", 32'(rom_sel), 32'(exp_rom(e_code)));

         for (int rnd = 0; rnd < 3; rnd++) begin
            int lat;
            int pulses;
            bit got;
            if (rnd == 0) begin
               // R3: glitch shorter than the filter length
               pulses = 0;
               pg_raw = 1'b1;
               repeat (DEB - 3) @(negedge clk);
               pg_raw = 1'b0;
               repeat (DEB + 8) begin
                  @(negedge clk);
                  if (g2_valid) pulses++;
               end
               chk("R3", 32'(pulses), 32'd0);
               check_g2("R3");
            end

            randomize_pins();
            if (rnd == 0 || cold[0]) pci_boot_pin = 1'b1;
            dbg_en_pin = 1'(rnd + cold);
            e_g2  = g2_pins;
            e_dbg = exp_dbg(dbg_en_pin, dbg_pins);
            e_den = dbg_en_pin;
            e_pci = (rnd == 0) ? pci_boot_pin : 1'b0;
            e_wdt = wdt_pin;

            pg_raw = 1'b1;
            lat = 0;
            got = 0;
            for (int k = 0; k < 100 && !got; k++) begin
               @(negedge clk);
               lat++;
               if (g2_valid) got = 1;
            end
            chk("R3", 32'(got), 32'd1);
            chk("R3", 32'(lat), 32'(DEB + SYNC + 1));
            chk("R4", 32'(g2_cfg), 32'(e_g2));
            chk("R5", 32'({dbg_en_cfg, dbg_cfg}), 32'({e_den, e_dbg}));
            chk("R7", 32'(pci_boot_cfg), 32'(e_pci));
            chk("R8", 32'(wdt_cfg), 32'(e_wdt));

            pulses = 0;
            repeat (20) begin
               @(negedge clk);
               if (g2_valid) pulses++;
            end
            chk("R4", 32'(pulses), 32'd0);

            randomize_pins();
            pg_raw = 1'b0;
            repeat (10) @(negedge clk);
            check_g2("R9");
            chk("R2", 32'(g1_cfg), 32'(e_g1));
         end
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule